// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block sits between wakeup and execute in an out-of-order core. Instructions whose operands are ready are written into it one per cycle, each carrying an operation class, a 16-bit sequence number, a thread id and an opaque tag. Every class has its own small pool of ready entries. Each cycle the block presents the oldest entry of every class that has a free functional unit. It then issues up to a fixed number of those heads, ordered by global age. Priority between classes is never fixed.

Two kill inputs act on the stored entries. A squash drops every entry of a thread that is younger than the squash sequence number. A commit drops every entry of a thread whose sequence number is at or below the commit point. An insert into a class pool that is already full is lost, and the block raises an error flag for one cycle.

Top module: `age_issue_selector`

## Requirements
- R1: While reset is high and on the first cycle after it, every `iss_valid` bit and `overflow_err` read 0.
- R2: Within one class, the entry with the smallest sequence number issues first, whatever the order of insertion.
- R3: Across classes, the eligible heads are issued by age. Slot 0 carries the oldest issued entry, and each higher slot carries a younger one.
- R4: At most ISSUE_W entries issue per cycle (2 by default), and at most one from any single class.
- R5: `fu_avail` bit i gates class i. While the bit is 0 the class issues nothing, and the selection moves on to the next-oldest eligible class.
- R6: An entry inserted at clock edge k can be selected at edge k+1 at the earliest. Its tag shows on `iss_tag` after edge k+1, and `iss_valid` stays low for it after edge k.
- R7: A squash with thread t and sequence s removes every entry of thread t whose sequence number is greater than s. Entries of other threads, and entries of t at or below s, remain. Removed entries are not issued in the squash cycle.
- R8: A commit with thread t and sequence s removes every entry of thread t whose sequence number is less than or equal to s.
- R9: An insert into a class that already holds DEPTH entries (8 by default) is dropped. `overflow_err` is 1 for the cycle after that edge, then returns to 0.
- R10: Issue slots fill from slot 0 upward. A slot with `iss_valid` low never sits below a valid one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert a ready entry this cycle |
| ins_class | input | CLS_W | Operation class of the insert |
| ins_tag | input | TAG_W | Tag carried to the issue output |
| ins_seq | input | SEQ_W | Sequence number (age) of the insert |
| ins_tid | input | TID_W | Thread id of the insert |
| fu_avail | input | NUM_CLASSES | Bit i set: a unit for class i is free |
| squash_valid | input | 1 | Apply a squash this cycle |
| squash_tid | input | TID_W | Thread being squashed |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| commit_valid | input | 1 | Apply a commit this cycle |
| commit_tid | input | TID_W | Thread being committed |
| commit_seq | input | SEQ_W | Entries at or below this are removed |
| iss_valid | output | ISSUE_W | Per-slot issue valid, registered |
| iss_tag | output | ISSUE_W x TAG_W | Per-slot issued tag, registered |
| overflow_err | output | 1 | One-cycle pulse after a dropped insert |

## Verification
A wrong head inside a class pool surfaces in the first issue cycle for that class, as a younger tag ahead of an older one. A corrupted kill mask shows up as a tag that should have vanished, or one that never appears, once the class drains. An error in the cross-class age ranking swaps slot contents or leaves a gap in the slots on the very next issue edge. A miscounted full condition either loses an older overflowing tag silently or lets a ninth tag appear while the pool drains.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;

    localparam int SEQ_W = 16;
    localparam int TAG_W = 6;
    localparam int TID_W = 1;

    typedef logic [SEQ_W-1:0] seq_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [TID_W-1:0] tid_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
        seq_t seq;
        tid_t tid;
    } iq_slot_t;

    // a strictly older than b (unsigned, no wrap assumed)
    function automatic logic seq_older(seq_t a, seq_t b);
        return a < b;
    endfunction

    // age order with index tie-break so ranks are always distinct
    function automatic logic head_older(seq_t a, int unsigned ia, seq_t b, int unsigned ib);
        return (a < b) || ((a == b) && (ia < ib));
    endfunction

endpackage

// File: rtl/iss_class_queue.sv
module iss_class_queue
    import iss_sel_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ins_en,
    input  tag_t ins_tag,
    input  seq_t ins_seq,
    input  tid_t ins_tid,
    input  logic sq_en,
    input  tid_t sq_tid,
    input  seq_t sq_seq,
    input  logic cm_en,
    input  tid_t cm_tid,
    input  seq_t cm_seq,
    input  logic pop,
    output logic head_vld,
    output seq_t head_seq,
    output tag_t head_tag,
    output logic ovf
);

    iq_slot_t ent_q [DEPTH];
    logic [DEPTH-1:0] vld, kill, live;
    logic [IDX_W-1:0] head_idx, free_idx;
    logic full;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld[i]  = ent_q[i].vld;
            kill[i] = ent_q[i].vld &&
                      ((sq_en && ent_q[i].tid == sq_tid && seq_older(sq_seq, ent_q[i].seq)) ||
                       (cm_en && ent_q[i].tid == cm_tid && !seq_older(cm_seq, ent_q[i].seq)));
            live[i] = vld[i] && !kill[i];
        end
    end

    // oldest surviving entry
    always_comb begin
        head_vld = 1'b0;
        head_idx = '0;
        head_seq = '0;
        head_tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live[i] && (!head_vld || seq_older(ent_q[i].seq, head_seq))) begin
                head_vld = 1'b1;
                head_idx = IDX_W'(i);
                head_seq = ent_q[i].seq;
                head_tag = ent_q[i].tag;
            end
        end
    end

    // lowest free slot
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

    assign full = &vld;
    assign ovf  = ins_en && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!live[i] || (pop && head_idx == IDX_W'(i))) ent_q[i].vld <= 1'b0;
            end
            if (ins_en && !full) begin
                ent_q[free_idx] <= '{vld: 1'b1, tag: ins_tag, seq: ins_seq, tid: ins_tid};
            end
        end
    end

    AST_POP_HAS_HEAD: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_vld);  // R4

    AST_OVF_DROP: assert property (@(posedge clk) disable iff (rst)
        (ins_en && full && !pop && kill == '0) |=> ($countones(vld) == $past($countones(vld))));  // R9

endmodule

// File: rtl/iss_age_picker.sv
module iss_age_picker
    import iss_sel_pkg::*;
#(
    parameter int NUM_CLASSES = 4,
    parameter int ISSUE_W = 2,
    localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
    localparam int RANK_W = $clog2(NUM_CLASSES + 1)
) (
    input  logic [NUM_CLASSES-1:0]            head_vld,
    input  logic [NUM_CLASSES-1:0][SEQ_W-1:0] head_seq,
    input  logic [NUM_CLASSES-1:0]            fu_avail,
    output logic [NUM_CLASSES-1:0]            grant,
    output logic [ISSUE_W-1:0]                slot_vld,
    output logic [ISSUE_W-1:0][CLS_W-1:0]     slot_cls
);

    logic [NUM_CLASSES-1:0] elig;
    logic [NUM_CLASSES-1:0][RANK_W-1:0] rank;

    assign elig = head_vld & fu_avail;

    // age matrix: rank of a class = eligible heads older than it
    always_comb begin
        for (int i = 0; i < NUM_CLASSES; i++) begin
            rank[i] = '0;
            for (int j = 0; j < NUM_CLASSES; j++) begin
                if (j != i && elig[j] &&
                    head_older(head_seq[j], j, head_seq[i], i))
                    rank[i] = rank[i] + 1'b1;
            end
            grant[i] = elig[i] && (int'(rank[i]) < ISSUE_W);
        end
    end

    // slot s takes the class whose rank is s
    always_comb begin
        for (int s = 0; s < ISSUE_W; s++) begin
            slot_vld[s] = 1'b0;
            slot_cls[s] = '0;
            for (int i = 0; i < NUM_CLASSES; i++) begin
                if (grant[i] && int'(rank[i]) == s) begin
                    slot_vld[s] = 1'b1;
                    slot_cls[s] = CLS_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/age_issue_selector.sv
module age_issue_selector
    import iss_sel_pkg::*;
#(
    parameter int NUM_CLASSES = 4,
    parameter int DEPTH = 8,
    parameter int ISSUE_W = 2,
    localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ins_valid,
    input  logic [CLS_W-1:0]                ins_class,
    input  logic [TAG_W-1:0]                ins_tag,
    input  logic [SEQ_W-1:0]                ins_seq,
    input  logic [TID_W-1:0]                ins_tid,
    input  logic [NUM_CLASSES-1:0]          fu_avail,
    input  logic                            squash_valid,
    input  logic [TID_W-1:0]                squash_tid,
    input  logic [SEQ_W-1:0]                squash_seq,
    input  logic                            commit_valid,
    input  logic [TID_W-1:0]                commit_tid,
    input  logic [SEQ_W-1:0]                commit_seq,
    output logic [ISSUE_W-1:0]              iss_valid,
    output logic [ISSUE_W-1:0][TAG_W-1:0]   iss_tag,
    output logic                            overflow_err
);

    logic [NUM_CLASSES-1:0]            head_vld, grant, ovf_vec;
    logic [NUM_CLASSES-1:0][SEQ_W-1:0] head_seq;
    logic [NUM_CLASSES-1:0][TAG_W-1:0] head_tag;
    logic [ISSUE_W-1:0]                slot_vld;
    logic [ISSUE_W-1:0][CLS_W-1:0]     slot_cls;
    logic [ISSUE_W-1:0][SEQ_W-1:0]     iss_seq_q;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        iss_class_queue #(.DEPTH(DEPTH)) u_q (
            .clk      (clk),
            .rst      (rst),
            .ins_en   (ins_valid && ins_class == CLS_W'(c)),
            .ins_tag  (ins_tag),
            .ins_seq  (ins_seq),
            .ins_tid  (ins_tid),
            .sq_en    (squash_valid),
            .sq_tid   (squash_tid),
            .sq_seq   (squash_seq),
            .cm_en    (commit_valid),
            .cm_tid   (commit_tid),
            .cm_seq   (commit_seq),
            .pop      (grant[c]),
            .head_vld (head_vld[c]),
            .head_seq (head_seq[c]),
            .head_tag (head_tag[c]),
            .ovf      (ovf_vec[c])
        );
    end

    iss_age_picker #(.NUM_CLASSES(NUM_CLASSES), .ISSUE_W(ISSUE_W)) u_pick (
        .head_vld (head_vld),
        .head_seq (head_seq),
        .fu_avail (fu_avail),
        .grant    (grant),
        .slot_vld (slot_vld),
        .slot_cls (slot_cls)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_valid    <= '0;
            iss_tag      <= '0;
            iss_seq_q    <= '0;
            overflow_err <= 1'b0;
        end else begin
            iss_valid    <= slot_vld;
            overflow_err <= |ovf_vec;
            for (int s = 0; s < ISSUE_W; s++) begin
                iss_tag[s]   <= head_tag[slot_cls[s]];
                iss_seq_q[s] <= head_seq[slot_cls[s]];
            end
        end
    end

    for (genvar s = 0; s + 1 < ISSUE_W; s++) begin : g_chk
        AST_SLOT_CONTIG: assert property (@(posedge clk) disable iff (rst)
            iss_valid[s+1] |-> iss_valid[s]);  // R10
        AST_SLOT_AGE: assert property (@(posedge clk) disable iff (rst)
            iss_valid[s+1] |-> seq_older(iss_seq_q[s], iss_seq_q[s+1]));  // R3
    end

    AST_ISSUE_CAP: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) <= ISSUE_W);  // R4

    AST_FU_RESPECT: assert property (@(posedge clk) disable iff (rst)
        (grant & ~fu_avail) == '0);  // R5

endmodule

// File: tb/age_issue_selector_tb_top.sv
`timescale 1ns/1ps
module age_issue_selector_tb_top;

    logic clk = 1'b0;
    logic rst;
    logic ins_valid;
    logic [1:0] ins_class;
    logic [5:0] ins_tag;
    logic [15:0] ins_seq;
    logic [0:0] ins_tid;
    logic [3:0] fu_avail;
    logic squash_valid, commit_valid;
    logic [0:0] squash_tid, commit_tid;
    logic [15:0] squash_seq, commit_seq;
    logic [1:0] iss_valid;
    logic [1:0][5:0] iss_tag;
    logic overflow_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    age_issue_selector dut_i (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_class(ins_class), .ins_tag(ins_tag),
        .ins_seq(ins_seq), .ins_tid(ins_tid), .fu_avail(fu_avail),
        .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_seq(squash_seq),
        .commit_valid(commit_valid), .commit_tid(commit_tid), .commit_seq(commit_seq),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .overflow_err(overflow_err)
    );

    // load table: class, seq, tag (class 0 loaded out of age order)
    localparam logic [1:0]  LD_CLS [8] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd2, 2'd3};
    localparam logic [15:0] LD_SEQ [8] = '{16'd12, 16'd10, 16'd11, 16'd20, 16'd5, 16'd30, 16'd25, 16'd7};
    localparam logic [5:0]  LD_TAG [8] = '{6'd2, 6'd1, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8};
    // expected tags per issue cycle: slot0, slot1
    localparam logic [5:0]  EX_TAG [8] = '{6'd5, 6'd8, 6'd1, 6'd3, 6'd2, 6'd4, 6'd7, 6'd6};

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_slot(input string req, input int s, input bit v, input int unsigned tag);
        chk(req, iss_valid[s], v);
        if (v) chk(req, iss_tag[s], tag);
    endtask

    task automatic put(input int cls, input int seq, input int tag, input int tid);
        ins_valid = 1'b1;
        ins_class = 2'(cls);
        ins_seq   = 16'(seq);
        ins_tag   = 6'(tag);
        ins_tid   = 1'(tid);
        tick();
        ins_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ins_valid = 0; ins_class = 0; ins_tag = 0; ins_seq = 0; ins_tid = 0;
        fu_avail = 4'b0000; squash_valid = 0; squash_tid = 0; squash_seq = 0;
        commit_valid = 0; commit_tid = 0; commit_seq = 0;
        repeat (3) tick();
        chk("R1 valid in reset", iss_valid, 0);
        chk("R1 ovf in reset", overflow_err, 0);
        rst = 1'b0;
        tick();
        chk("R1 valid after reset", iss_valid, 0);
        chk("R1 ovf after reset", overflow_err, 0);

        // table walk: R2, R3, R4
        for (int i = 0; i < 8; i++) put(LD_CLS[i], LD_SEQ[i], LD_TAG[i], 0);
        fu_avail = 4'b1111;
        for (int c = 0; c < 4; c++) begin
            tick();
            chk_slot("R3 slot0 table", 0, 1, EX_TAG[2*c]);
            chk_slot("R2 R4 slot1 table", 1, 1, EX_TAG[2*c+1]);
        end
        tick();
        chk("R10 table drained", iss_valid, 0);

        // FU busy skip: R5
        fu_avail = 4'b0000;
        put(0, 1, 9, 0); put(1, 2, 10, 0); put(2, 3, 11, 0);
        fu_avail = 4'b1110;
        tick();
        chk_slot("R5 skip busy slot0", 0, 1, 10);
        chk_slot("R5 skip busy slot1", 1, 1, 11);
        fu_avail = 4'b1111;
        tick();
        chk_slot("R5 busy class later", 0, 1, 9);
        chk("R10 slot1 empty", iss_valid[1], 0);

        // same class, one per cycle: R4
        fu_avail = 4'b0000;
        put(0, 2, 13, 0); put(0, 1, 12, 0);
        fu_avail = 4'b1111;
        tick();
        chk_slot("R4 one per class a", 0, 1, 12);
        chk("R4 one per class b", iss_valid[1], 0);
        tick();
        chk_slot("R2 next in class", 0, 1, 13);

        // insert latency: R6
        tick();
        put(0, 60, 30, 0);
        chk("R6 not yet issued", iss_valid, 0);
        tick();
        chk_slot("R6 issued next", 0, 1, 30);

        // squash: R7
        fu_avail = 4'b0000;
        put(0, 40, 20, 0); put(1, 41, 21, 0); put(2, 42, 22, 1); put(3, 43, 23, 0);
        squash_valid = 1; squash_tid = 0; squash_seq = 40;
        tick();
        squash_valid = 0;
        fu_avail = 4'b1111;
        tick();
        chk_slot("R7 kept slot0", 0, 1, 20);
        chk_slot("R7 other thread kept", 1, 1, 22);
        tick();
        chk("R7 younger removed", iss_valid, 0);

        // commit: R8
        fu_avail = 4'b0000;
        put(0, 50, 24, 0); put(1, 51, 25, 1); put(2, 52, 26, 0);
        commit_valid = 1; commit_tid = 0; commit_seq = 51;
        tick();
        commit_valid = 0;
        fu_avail = 4'b1111;
        tick();
        chk_slot("R8 slot0", 0, 1, 25);
        chk_slot("R8 slot1", 1, 1, 26);
        tick();
        chk("R8 committed removed", iss_valid, 0);

        // overflow: R9
        fu_avail = 4'b0000;
        for (int k = 0; k < 8; k++) put(1, 100 + k, 40 + k, 0);
        chk("R9 no ovf when filling", overflow_err, 0);
        put(1, 99, 48, 0);
        chk("R9 ovf pulse", overflow_err, 1);
        tick();
        chk("R9 ovf clears", overflow_err, 0);
        fu_avail = 4'b1111;
        for (int k = 0; k < 8; k++) begin
            tick();
            chk_slot("R9 drain keeps stored", 0, 1, 40 + k);
        end
        tick();
        chk("R9 dropped entry absent", iss_valid, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule